// File: doc/BRIEF.md
# DDR2 Write-Burst Command Timing Checker

This block sits beside an SDRAM controller and watches its decoded command stream. It takes one command per clock: a three-bit command code and a bank number. It checks each command against the write-burst rules of a DDR2-style device. When a command arrives too early, or cuts off a burst that may not be shortened, the block raises a one-cycle violation pulse with a reason code. It also drives a window signal that marks the clock edges at which the device would accept write data.

Burst length, CAS latency (CL), write recovery (tWR) and write-to-read delay (tWTR) are configuration inputs. The clock counts are held as static for as long as any write activity is in flight.

A five-state burst tracker follows the command periods of the most recent WRITE:

| State | Meaning |
|---|---|
| `BS_IDLE` | No write burst is occupying command slots. |
| `BS_B4_TAIL` | Second command slot of a BL4 write. |
| `BS_B8_P1` | Second slot of a BL8 write. |
| `BS_B8_P2` | Third slot of a BL8 write, which is the 4-beat boundary. |
| `BS_B8_P3` | Fourth slot of a BL8 write. |

Transitions:

- Any WRITE moves the tracker to `BS_B8_P1` when the burst length is 8, or to `BS_B4_TAIL` when it is 4. This applies in every state, whether or not the WRITE is flagged.
- With no WRITE, the tracker steps `BS_B8_P1` → `BS_B8_P2` → `BS_B8_P3` → `BS_IDLE`.
- With no WRITE, `BS_B4_TAIL` → `BS_IDLE`, and `BS_IDLE` stays where it is.

Separate down-counters track the write-to-read delay for all banks together and the write recovery for each bank. A delay line tracks the data window.

Top module: `wr_burst_guard`

## Requirements
- R1: Synchronous active-high `rst` clears all tracking. Afterwards `viol` is 0, `viol_rsn` is 0 and `wdata_win` is 0. A READ, PRECHARGE or ACTIVATE issued straight after reset is not flagged, even if a WRITE came just before the reset.
- R2: The command codes are:
  - 0 = NOP
  - 1 = ACTIVATE
  - 2 = READ
  - 3 = WRITE
  - 4 = PRECHARGE

  A command sampled at clock edge t is judged at that edge. `viol` is high during the clock period that follows edge t, for that command only. `viol_rsn` then holds the reason:
  - 1 = BL4 interrupted
  - 2 = illegal BL8 cut
  - 3 = READ too early
  - 4 = write recovery too early

  When `viol` is 0, `viol_rsn` is 0.
- R3: Let k be the number of clocks since the last WRITE. With burst length 4 (`cfg_bl8`=0), any command other than NOP at k=1 is flagged with reason 1.
- R4: With burst length 8, a WRITE at k=2 is legal and cuts the burst at 4 beats. A WRITE at k=1 or k=3 is flagged with reason 2.
- R5: With burst length 8, a READ, PRECHARGE or ACTIVATE at k=1, 2 or 3 is flagged with reason 2.
- R6: A WRITE at k=BL/2 is legal, and its data follows the previous burst without a gap.
- R7: A READ to any bank is flagged with reason 3 unless k ≥ (CL−1) + BL/2 + max(2, tWTR). Here k counts from the last WRITE to any bank.
- R8: A PRECHARGE or ACTIVATE to bank b is flagged with reason 4 unless k_b ≥ (CL−1) + BL/2 + tWR. Here k_b counts from the last WRITE to bank b, so tWR starts at the end of that burst. Writes to other banks have no effect on this check.
- R9: For a WRITE at edge t, `wdata_win` is high at edges t+CL−1 through t+CL−2+BL/2. Overlapping windows merge. At every other edge it is low.
- R10: Codes 5, 6 and 7 act as NOP. They are never flagged and they do not disturb any burst in progress.
- R11: Only one reason is reported per command. Truncation reasons (1 and 2) take priority over 3, and 3 takes priority over 4. Every command updates the tracking state, flagged or not; a flagged WRITE restarts all delays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_code | input | 3 | Command code (R2) |
| cmd_bank | input | BANK_W (3) | Target bank |
| cfg_bl8 | input | 1 | 1 = burst length 8, 0 = burst length 4 |
| cfg_cl | input | CL_W (3) | CAS latency in clocks, 2 to 7 |
| cfg_twr | input | T_W (4) | Write recovery in clocks |
| cfg_twtr | input | T_W (4) | Write-to-read delay in clocks; values below 2 act as 2 |
| viol | output | 1 | Violation pulse for the previous command |
| viol_rsn | output | 3 | Reason code (R2) |
| wdata_win | output | 1 | Write data accepted at the next edge |

## Verification
The hardest case to reach is the 4-beat boundary of a BL8 burst. A stray command there must be caught, yet a WRITE there must pass, and the write-to-read and recovery delays must then restart from the new WRITE. A random stream rarely lands a WRITE exactly two clocks after another. The stimulus therefore places WRITE, READ, PRECHARGE and ACTIVATE at k=1, 2, 3 and 4, and at one clock either side of each delay limit. Random segments then follow under several latency and burst settings, each started from a quiet gap.

// File: rtl/wbg_pkg.sv
package wbg_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        RSN_NONE   = 3'd0,
        RSN_TRUNC4 = 3'd1,
        RSN_TRUNC8 = 3'd2,
        RSN_WTR    = 3'd3,
        RSN_WREC   = 3'd4
    } rsn_e;

    typedef enum logic [2:0] {
        BS_IDLE    = 3'd0,
        BS_B4_TAIL = 3'd1,
        BS_B8_P1   = 3'd2,
        BS_B8_P2   = 3'd3,
        BS_B8_P3   = 3'd4
    } bstate_e;

endpackage

// File: rtl/wbg_burst_fsm.sv
module wbg_burst_fsm
    import wbg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    is_cmd,
    input  logic    is_wr,
    input  logic    bl8,
    output bstate_e state,
    output logic    trunc_hit,
    output rsn_e    trunc_rsn,
    output logic    chain_ok
);

    bstate_e state_q;
    bstate_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (is_wr) begin
            state_d = bl8 ? BS_B8_P1 : BS_B4_TAIL;
        end else begin
            unique case (state_q)
                BS_IDLE:    state_d = BS_IDLE;
                BS_B4_TAIL: state_d = BS_IDLE;
                BS_B8_P1:   state_d = BS_B8_P2;
                BS_B8_P2:   state_d = BS_B8_P3;
                BS_B8_P3:   state_d = BS_IDLE;
                default:    state_d = BS_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        trunc_hit = 1'b0;
        trunc_rsn = RSN_NONE;
        chain_ok  = 1'b0;
        unique case (state_q)
            BS_IDLE: begin
            end
            BS_B4_TAIL: begin
                if (is_cmd) begin
                    trunc_hit = 1'b1;
                    trunc_rsn = RSN_TRUNC4;
                end
            end
            BS_B8_P1, BS_B8_P3: begin
                if (is_cmd) begin
                    trunc_hit = 1'b1;
                    trunc_rsn = RSN_TRUNC8;
                end
            end
            BS_B8_P2: begin
                if (is_wr) begin
                    chain_ok = 1'b1;
                end else if (is_cmd) begin
                    trunc_hit = 1'b1;
                    trunc_rsn = RSN_TRUNC8;
                end
            end
            default: begin
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/wbg_delay_cnt.sv
module wbg_delay_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/wbg_data_window.sv
module wbg_data_window #(
    parameter int CL_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_start,
    input  logic            bl8,
    input  logic [CL_W-1:0] wl,
    output logic            win
);

    localparam int DEPTH = 1 << CL_W;

    logic [DEPTH-1:0] start_pipe;
    logic [DEPTH-1:0] len_pipe;
    logic [1:0]       beat_q;
    logic [CL_W-1:0]  tap;
    logic             fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_pipe <= '0;
            len_pipe   <= '0;
        end else begin
            start_pipe <= {start_pipe[DEPTH-2:0], wr_start};
            len_pipe   <= {len_pipe[DEPTH-2:0], bl8};
        end
    end

    assign tap  = wl - 1'b1;
    assign fire = (wl != '0) && start_pipe[tap];

    // beats remaining after the first window clock
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (fire) begin
            beat_q <= len_pipe[tap] ? 2'd3 : 2'd1;
        end else if (beat_q != 2'd0) begin
            beat_q <= beat_q - 1'b1;
        end
    end

    assign win = fire || (beat_q != 2'd0);

endmodule

// File: rtl/wr_burst_guard.sv
module wr_burst_guard
    import wbg_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int CL_W  = 3,
    parameter int T_W   = 4,
    localparam int BANK_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd_code,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic              cfg_bl8,
    input  logic [CL_W-1:0]   cfg_cl,
    input  logic [T_W-1:0]    cfg_twr,
    input  logic [T_W-1:0]    cfg_twtr,
    output logic              viol,
    output logic [2:0]        viol_rsn,
    output logic              wdata_win
);

    localparam int CNT_W = ((CL_W > T_W) ? CL_W : T_W) + 2;

    logic is_cmd;
    logic is_wr;
    logic is_rd;
    logic is_row;

    assign is_wr  = (cmd_code == CMD_WR);
    assign is_rd  = (cmd_code == CMD_RD);
    assign is_row = (cmd_code == CMD_PRE) || (cmd_code == CMD_ACT);
    assign is_cmd = is_wr || is_rd || is_row;

    // delay loads, taken at the WRITE
    logic [CNT_W-1:0] half_c;
    logic [CNT_W-1:0] wl_c;
    logic [CNT_W-1:0] twtr_c;
    logic [CNT_W-1:0] rd_load;
    logic [CNT_W-1:0] wr_load;
    logic [CL_W-1:0]  wl_short;

    always_comb begin
        half_c   = cfg_bl8 ? CNT_W'(4) : CNT_W'(2);
        wl_c     = CNT_W'(cfg_cl) - CNT_W'(1);
        twtr_c   = (cfg_twtr < T_W'(2)) ? CNT_W'(2) : CNT_W'(cfg_twtr);
        rd_load  = wl_c + half_c + twtr_c - CNT_W'(1);
        wr_load  = wl_c + half_c + CNT_W'(cfg_twr) - CNT_W'(1);
        wl_short = cfg_cl - 1'b1;
    end

    // burst tracker
    bstate_e bst;
    logic    trunc_hit;
    rsn_e    trunc_rsn;
    logic    chain_ok;

    wbg_burst_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .is_cmd    (is_cmd),
        .is_wr     (is_wr),
        .bl8       (cfg_bl8),
        .state     (bst),
        .trunc_hit (trunc_hit),
        .trunc_rsn (trunc_rsn),
        .chain_ok  (chain_ok)
    );

    // write-to-read, shared by all banks
    logic rd_busy;

    wbg_delay_cnt #(.W(CNT_W)) u_wtr (
        .clk      (clk),
        .rst      (rst),
        .load     (is_wr),
        .load_val (rd_load),
        .busy     (rd_busy)
    );

    // write recovery, one per bank
    logic [NBANK-1:0] bank_busy;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        wbg_delay_cnt #(.W(CNT_W)) u_wrec (
            .clk      (clk),
            .rst      (rst),
            .load     (is_wr && (cmd_bank == BANK_W'(b))),
            .load_val (wr_load),
            .busy     (bank_busy[b])
        );
    end

    // data window
    wbg_data_window #(.CL_W(CL_W)) u_win (
        .clk      (clk),
        .rst      (rst),
        .wr_start (is_wr),
        .bl8      (cfg_bl8),
        .wl       (wl_short),
        .win      (wdata_win)
    );

    // verdict, priority ordered
    rsn_e rsn_d;

    always_comb begin
        if (trunc_hit) begin
            rsn_d = trunc_rsn;
        end else if (chain_ok) begin
            rsn_d = RSN_NONE;
        end else if (is_rd && rd_busy) begin
            rsn_d = RSN_WTR;
        end else if (is_row && bank_busy[cmd_bank]) begin
            rsn_d = RSN_WREC;
        end else begin
            rsn_d = RSN_NONE;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            viol     <= 1'b0;
            viol_rsn <= RSN_NONE;
        end else begin
            viol     <= (rsn_d != RSN_NONE);
            viol_rsn <= rsn_d;
        end
    end

endmodule

// File: rtl/wbg_chk.sv
module wbg_chk
    import wbg_pkg::*;
#(
    parameter int CL_W = 3
) (
    input logic            clk,
    input logic            rst,
    input logic [2:0]      cmd_code,
    input logic [CL_W-1:0] cfg_cl,
    input logic            viol,
    input logic [2:0]      viol_rsn,
    input logic            wdata_win,
    input logic [2:0]      fsm_state
);

    // R2
    flag_has_reason_chk: assert property (@(posedge clk) disable iff (rst)
        viol |-> (viol_rsn != 3'd0));

    // R2
    quiet_reason_chk: assert property (@(posedge clk) disable iff (rst)
        !viol |-> (viol_rsn == 3'd0));

    // R3
    bl4_cut_chk: assert property (@(posedge clk) disable iff (rst)
        ((fsm_state == BS_B4_TAIL) && (cmd_code >= 3'd1) && (cmd_code <= 3'd4))
        |=> (viol && (viol_rsn == RSN_TRUNC4)));

    // R4
    bl8_chain_chk: assert property (@(posedge clk) disable iff (rst)
        ((fsm_state == BS_B8_P2) && (cmd_code == CMD_WR)) |=> !viol);

    // R5
    bl8_intrude_chk: assert property (@(posedge clk) disable iff (rst)
        ((fsm_state == BS_B8_P1) &&
         ((cmd_code == CMD_RD) || (cmd_code == CMD_PRE) || (cmd_code == CMD_ACT)))
        |=> (viol_rsn == RSN_TRUNC8));

    // R9
    early_window_chk: assert property (@(posedge clk) disable iff (rst)
        ((cmd_code == CMD_WR) && (cfg_cl == CL_W'(2))) |=> wdata_win);

    // R10
    odd_code_chk: assert property (@(posedge clk) disable iff (rst)
        ((cmd_code > 3'd4) && (fsm_state == BS_IDLE)) |=> !viol);

endmodule

bind wr_burst_guard wbg_chk #(.CL_W(CL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_code  (cmd_code),
    .cfg_cl    (cfg_cl),
    .viol      (viol),
    .viol_rsn  (viol_rsn),
    .wdata_win (wdata_win),
    .fsm_state (bst)
);

// File: tb/sim_wr_burst_guard.sv
module sim_wr_burst_guard;

    localparam int NB = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cmd_code = 3'd0;
    logic [2:0] cmd_bank = 3'd0;
    logic       cfg_bl8 = 1'b0;
    logic [2:0] cfg_cl = 3'd4;
    logic [3:0] cfg_twr = 4'd3;
    logic [3:0] cfg_twtr = 4'd1;
    logic       viol;
    logic [2:0] viol_rsn;
    logic       wdata_win;

    wr_burst_guard u0 (
        .clk       (clk),
        .rst       (rst),
        .cmd_code  (cmd_code),
        .cmd_bank  (cmd_bank),
        .cfg_bl8   (cfg_bl8),
        .cfg_cl    (cfg_cl),
        .cfg_twr   (cfg_twr),
        .cfg_twtr  (cfg_twtr),
        .viol      (viol),
        .viol_rsn  (viol_rsn),
        .wdata_win (wdata_win)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // behavioural reference state
    int e_now = 0;
    int last_wr = -100000;
    int last_n = 2;
    int bank_wr[NB];
    int bank_n[NB];
    bit win_mark[int];

    function automatic void model_clear();
        last_wr = -100000;
        last_n  = 2;
        for (int i = 0; i < NB; i++) begin
            bank_wr[i] = -100000;
            bank_n[i]  = 2;
        end
        win_mark.delete();
    endfunction

    function automatic void model_cmd(input int c, input int b,
                                      output int exp, output string tag);
        int k, kb, n, wl, te;
        bit real_cmd;
        k  = e_now - last_wr;
        n  = last_n;
        wl = int'(cfg_cl) - 1;
        te = (cfg_twtr < 2) ? 2 : int'(cfg_twtr);
        real_cmd = (c >= 1) && (c <= 4);
        exp = 0;
        tag = (c > 4) ? "R10" : "R2";
        if (real_cmd && k < n) begin
            if (n == 2) begin
                exp = 1;
                tag = (c == 3) ? "R3" : "R11";
            end else if (c == 3 && k == 2) begin
                tag = "R4";
            end else begin
                exp = 2;
                tag = (c == 3) ? "R4" : "R5";
            end
        end else if (c == 2) begin
            tag = "R7";
            if (k < wl + n + te) exp = 3;
        end else if (c == 1 || c == 4) begin
            tag = "R8";
            kb = e_now - bank_wr[b];
            if (kb < wl + bank_n[b] + int'(cfg_twr)) exp = 4;
        end else if (c == 3 && k == n) begin
            tag = "R6";
        end
        if (c == 3) begin
            last_wr = e_now;
            last_n  = cfg_bl8 ? 4 : 2;
            bank_wr[b] = e_now;
            bank_n[b]  = last_n;
            for (int i = 0; i < last_n; i++) win_mark[e_now + wl + i] = 1'b1;
        end
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (edge %0d)",
                     tag, what, act, exp, e_now);
        end
    endtask

    // one command slot: drive, edge, model, sample at the falling edge
    task automatic step(input int c, input int b);
        int exp;
        string tag;
        bit wexp;
        cmd_code = 3'(c);
        cmd_bank = 3'(b);
        @(posedge clk);
        e_now++;
        model_cmd(c, b, exp, tag);
        @(negedge clk);
        check((viol == (exp != 0)) && (int'(viol_rsn) == exp), tag,
              "reason", viol ? int'(viol_rsn) : 0, exp);
        wexp = win_mark.exists(e_now + 1);
        check(wdata_win == wexp, "R9", "window", int'(wdata_win), int'(wexp));
    endtask

    task automatic idle(input int cnt);
        for (int i = 0; i < cnt; i++) step(0, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cmd_code = 3'd0;
        repeat (3) begin
            @(posedge clk);
            e_now++;
        end
        model_clear();
        @(negedge clk);
        check(!viol && viol_rsn == 3'd0 && !wdata_win, "R1", "reset outputs",
              {29'd0, viol, wdata_win, |viol_rsn}, 0);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_clear();
        @(negedge clk);
        do_reset();

        // R1: delays cleared by reset
        step(3, 0);
        do_reset();
        step(2, 0);
        step(4, 0);
        idle(12);

        // burst length 4, CL 4, tWR 3, tWTR 1 (acts as 2)
        cfg_bl8 = 1'b0;
        step(3, 0); step(2, 0); idle(20);             // R11 READ inside BL4
        step(3, 0); step(3, 1); idle(20);             // R3
        step(3, 0); step(1, 2); idle(20);             // R3 ACT cut
        step(3, 0); step(0, 0); step(3, 1); idle(20); // R6
        step(3, 0); idle(5); step(2, 3); idle(20);    // R7 k=6 early
        step(3, 0); idle(6); step(2, 3); idle(20);    // R7 k=7 legal
        step(3, 1); idle(6); step(4, 1); idle(20);    // R8 k=7 early
        step(3, 1); idle(7); step(4, 1); idle(20);    // R8 k=8 legal
        step(3, 1); idle(2); step(4, 2); idle(20);    // R8 other bank
        step(3, 1); step(6, 0); step(7, 0); idle(20); // R10

        // burst length 8, tWTR 9
        cfg_bl8 = 1'b1;
        cfg_twtr = 4'd9;
        step(3, 0); step(0, 0); step(3, 0); idle(20); // R4 legal cut
        step(3, 0); step(3, 0); idle(20);             // R4 k=1
        step(3, 0); idle(2); step(3, 0); idle(20);    // R4 k=3
        step(3, 0); step(0, 0); step(4, 0); idle(20); // R5 k=2
        step(3, 0); idle(2); step(1, 5); idle(20);    // R5 k=3
        step(3, 0); step(2, 0); idle(20);             // R5 k=1
        step(3, 0); idle(3); step(3, 4); idle(20);    // R6
        step(3, 2); idle(14); step(2, 0); idle(20);   // R7 k=15 early
        step(3, 2); idle(15); step(2, 0); idle(20);   // R7 k=16 legal
        step(3, 0); step(0, 0); step(3, 6); idle(12); step(2, 0); idle(30); // R11
        step(3, 0); step(5, 0); step(3, 0); idle(20); // R10 inside burst

        // random segments under several settings
        for (int s = 0; s < 8; s++) begin
            idle(40);
            cfg_bl8  = s[0];
            cfg_cl   = 3'(2 + (s % 6));
            cfg_twr  = 4'($urandom_range(0, 15));
            cfg_twtr = 4'($urandom_range(0, 15));
            for (int i = 0; i < 500; i++) begin
                int r;
                int c;
                r = $urandom_range(0, 11);
                c = (r < 5) ? 0 : (r < 7) ? 3 : (r == 7) ? 2 :
                    (r == 8) ? 4 : (r == 9) ? 1 : (r == 10) ? 6 : 0;
                step(c, $urandom_range(0, NB - 1));
            end
        end
        idle(40);
        finish_run();
    end

endmodule